// File: doc/BRIEF.md
# System Management Mode Sideband Pin Controller

This block sits between a chipset and a processor's sideband control pins. It keeps a small mode register that software writes. The register decides how four processor-facing pins behave when the processor enters system management mode or is already in it: the cache flush strobe, the A20 mask line, the cache-enable line and the soft-reset path. While a pin has no override in force, it passes its upstream source straight through.

Two conventions are supported for telling that the processor is in system management mode. In the level convention, an active-low status line from the processor is read directly. In the strobe-qualified convention, that status line is sampled only in cycles where the processor's active-low address strobe is asserted, and the result is held between strobes.

When the mode flag is set, entering the mode produces a single-clock flush pulse. Another flag turns soft-reset requests into a management interrupt request instead of passing them on.

Top module: `smm_pin_ctrl`

## Requirements
- R1: After reset the mode register reads 00h, `flush_n` is 1, and every pin output equals its upstream input (`soft_rst_out` = `soft_rst_in`, `smi_req` = 0).
- R2: A write with `cfg_wr_en` = 1 is stored at the clock edge. `cfg_rd_data` then shows written bits 4:0, and bits 7:5 always read as 0.
- R3: When register bit 0 = 0 (level convention), the block is in management mode in the same cycle that `smm_sig_n` is 0, and it is not in management mode while `smm_sig_n` is 1.
- R4: When bit 0 = 1 (strobe convention), the management state is loaded with the inverse of `smm_sig_n` at each clock edge where `smm_ads_n` = 0. In every other cycle it holds its value.
- R5: With bit 1 = 1, a change of the management state from inactive to active drives `flush_n` to 0 for exactly the one clock cycle after that edge. Staying in the mode produces no further pulse, and with bit 1 = 0 `flush_n` stays at 1.
- R6: With bit 2 = 1 and the block in management mode, `a20m_out_n` = 1. In every other case it equals `a20m_in_n`.
- R7: With bit 3 = 1, the block in management mode and `bus_cyc` = 1, `ken_out_n` = 1. In every other case it equals `ken_in_n`.
- R8: With bit 4 = 1, `soft_rst_out` = 0 and `smi_req` = `soft_rst_in`. With bit 4 = 0, `soft_rst_out` = `soft_rst_in` and `smi_req` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Mode register write strobe |
| cfg_wr_data | input | 8 | Mode register write value |
| cfg_rd_data | output | 8 | Mode register read value, reserved bits as 0 |
| smm_sig_n | input | 1 | Processor management-mode status, active low |
| smm_ads_n | input | 1 | Processor address strobe, active low |
| bus_cyc | input | 1 | High during a processor memory access that can be cached |
| a20m_in_n | input | 1 | Upstream A20 mask level |
| ken_in_n | input | 1 | Upstream cache-enable level |
| soft_rst_in | input | 1 | Soft-reset request from upstream |
| flush_n | output | 1 | Cache flush strobe to the processor, active low |
| a20m_out_n | output | 1 | A20 mask to the processor |
| ken_out_n | output | 1 | Cache enable to the processor |
| soft_rst_out | output | 1 | Soft reset passed on to the processor |
| smi_req | output | 1 | Management interrupt request from a redirected soft reset |

## Verification
The bench builds the block with its default register width of 8, so the three reserved bits exist and their reads as zero can be checked. Because that width is used as-is, every mode flag sits at a fixed bit position, and the stimulus table can combine several flags in a single write. The default two-state strobe tracker makes it possible to hold the strobe convention across several strobe-free cycles and then watch a single strobe change the pin overrides.

// File: rtl/smm_pin_pkg.sv
package smm_pin_pkg;

  localparam int unsigned MODE_BITS = 5;

  localparam int unsigned BIT_STYLE = 0;
  localparam int unsigned BIT_FLUSH = 1;
  localparam int unsigned BIT_A20   = 2;
  localparam int unsigned BIT_KEN   = 3;
  localparam int unsigned BIT_REDIR = 4;

  typedef struct packed {
    logic redir_rst;
    logic force_ken;
    logic force_a20;
    logic flush_on_entry;
    logic strobe_style;
  } smm_mode_t;

  function automatic smm_mode_t mode_from_bits(input logic [MODE_BITS-1:0] b);
    smm_mode_t m;
    m.strobe_style   = b[BIT_STYLE];
    m.flush_on_entry = b[BIT_FLUSH];
    m.force_a20      = b[BIT_A20];
    m.force_ken      = b[BIT_KEN];
    m.redir_rst      = b[BIT_REDIR];
    return m;
  endfunction

  // Drive an active-low pin inactive (high) when forced, else pass it on.
  function automatic logic pin_override(input logic force_hi, input logic src_n);
    return force_hi ? 1'b1 : src_n;
  endfunction

  // A rising edge of the management state.
  function automatic logic rising(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

endpackage

// File: rtl/smm_mode_reg.sv
module smm_mode_reg
  import smm_pin_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output smm_mode_t         mode
);
  localparam int unsigned RSV_W = DATA_W - MODE_BITS;

  logic [MODE_BITS-1:0] mode_q;
  logic                 unused_rsv;

  assign unused_rsv = ^wr_data[DATA_W-1:MODE_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_q <= '0;
    else if (wr_en)
      mode_q <= wr_data[MODE_BITS-1:0];
  end

  assign rd_data = {{RSV_W{1'b0}}, mode_q};
  assign mode    = mode_from_bits(mode_q);
endmodule

// File: rtl/smm_state_track.sv
module smm_state_track
  import smm_pin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_style,
  input  logic smm_sig_n,
  input  logic smm_ads_n,
  output logic in_smm,
  output logic smm_entry
);
  logic strobed_q;
  logic in_smm_q;

  // Strobe-qualified tracker: sampled only when the address strobe is low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      strobed_q <= 1'b0;
    else if (!smm_ads_n)
      strobed_q <= ~smm_sig_n;
  end

  assign in_smm = strobe_style ? strobed_q : ~smm_sig_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      in_smm_q <= 1'b0;
    else
      in_smm_q <= in_smm;
  end

  assign smm_entry = rising(in_smm, in_smm_q);
endmodule

// File: rtl/smm_flush_gen.sv
module smm_flush_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic smm_entry,
  output logic flush_n
);
  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pulse_q <= 1'b0;
    else
      pulse_q <= enable & smm_entry;
  end

  assign flush_n = ~pulse_q;
endmodule

// File: rtl/smm_pin_mux.sv
module smm_pin_mux
  import smm_pin_pkg::*;
(
  input  smm_mode_t mode,
  input  logic      in_smm,
  input  logic      bus_cyc,
  input  logic      a20m_in_n,
  input  logic      ken_in_n,
  input  logic      soft_rst_in,
  output logic      a20m_out_n,
  output logic      ken_out_n,
  output logic      soft_rst_out,
  output logic      smi_req
);
  logic a20_force;
  logic ken_force;

  assign a20_force    = mode.force_a20 & in_smm;
  assign ken_force    = mode.force_ken & in_smm & bus_cyc;
  assign a20m_out_n   = pin_override(a20_force, a20m_in_n);
  assign ken_out_n    = pin_override(ken_force, ken_in_n);
  assign soft_rst_out = soft_rst_in & ~mode.redir_rst;
  assign smi_req      = soft_rst_in & mode.redir_rst;
endmodule

// File: rtl/smm_pin_ctrl.sv
module smm_pin_ctrl
  import smm_pin_pkg::*;
#(
  parameter int unsigned CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  output logic [CFG_W-1:0] cfg_rd_data,
  input  logic             smm_sig_n,
  input  logic             smm_ads_n,
  input  logic             bus_cyc,
  input  logic             a20m_in_n,
  input  logic             ken_in_n,
  input  logic             soft_rst_in,
  output logic             flush_n,
  output logic             a20m_out_n,
  output logic             ken_out_n,
  output logic             soft_rst_out,
  output logic             smi_req
);
  smm_mode_t mode;
  logic      in_smm;
  logic      smm_entry;

  smm_mode_reg #(.DATA_W(CFG_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .rd_data (cfg_rd_data),
    .mode    (mode)
  );

  smm_state_track u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_style (mode.strobe_style),
    .smm_sig_n    (smm_sig_n),
    .smm_ads_n    (smm_ads_n),
    .in_smm       (in_smm),
    .smm_entry    (smm_entry)
  );

  smm_flush_gen u_flush (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (mode.flush_on_entry),
    .smm_entry (smm_entry),
    .flush_n   (flush_n)
  );

  smm_pin_mux u_mux (
    .mode         (mode),
    .in_smm       (in_smm),
    .bus_cyc      (bus_cyc),
    .a20m_in_n    (a20m_in_n),
    .ken_in_n     (ken_in_n),
    .soft_rst_in  (soft_rst_in),
    .a20m_out_n   (a20m_out_n),
    .ken_out_n    (ken_out_n),
    .soft_rst_out (soft_rst_out),
    .smi_req      (smi_req)
  );
endmodule

// File: rtl/smm_pin_ctrl_chk.sv
module smm_pin_ctrl_chk #(
  parameter int unsigned CFG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr_en,
  input logic [CFG_W-1:0] cfg_rd_data,
  input logic             smm_ads_n,
  input logic             in_smm,
  input logic             smm_entry,
  input logic             flush_n,
  input logic             a20m_out_n,
  input logic             soft_rst_in,
  input logic             soft_rst_out,
  input logic             smi_req
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[CFG_W-1:5] == '0);

  assert_strobe_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data[0] && smm_ads_n && !cfg_wr_en) |=> $stable(in_smm));

  assert_flush_after_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smm_entry && cfg_rd_data[1]) |=> !flush_n);

  assert_flush_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_n |=> flush_n);

  assert_flush_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_n |-> $past(smm_entry && cfg_rd_data[1]));

  assert_a20_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_smm && cfg_rd_data[2]) |-> a20m_out_n);

  assert_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[4] |-> (!soft_rst_out && (smi_req == soft_rst_in)));
endmodule

bind smm_pin_ctrl smm_pin_ctrl_chk #(.CFG_W(CFG_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_wr_en    (cfg_wr_en),
  .cfg_rd_data  (cfg_rd_data),
  .smm_ads_n    (smm_ads_n),
  .in_smm       (in_smm),
  .smm_entry    (smm_entry),
  .flush_n      (flush_n),
  .a20m_out_n   (a20m_out_n),
  .soft_rst_in  (soft_rst_in),
  .soft_rst_out (soft_rst_out),
  .smi_req      (smi_req)
);

// File: tb/test_smm_pin_ctrl.sv
module test_smm_pin_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  // {mode[4:0], sig_n, bus, a20_in, ken_in, soft | a20_out, ken_out, srst_out, smi}
  localparam logic [13:0] VEC [NVEC] = '{
    14'b00000_1_0_0_0_0_0_0_0_0,
    14'b00000_0_1_0_0_1_0_0_1_0,
    14'b00100_0_0_0_0_0_1_0_0_0,
    14'b00100_1_0_0_1_0_0_1_0_0,
    14'b01000_0_1_0_0_0_0_1_0_0,
    14'b01000_0_0_1_0_0_1_0_0_0,
    14'b01000_1_1_0_0_0_0_0_0_0,
    14'b10000_1_0_0_0_1_0_0_0_1,
    14'b10000_1_0_0_0_0_0_0_0_0,
    14'b11100_0_1_0_0_1_1_1_0_1,
    14'b01100_0_1_1_1_0_1_1_0_0,
    14'b00000_0_1_1_1_1_1_1_1_0
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = 8'h00;
  logic [7:0] cfg_rd_data;
  logic       smm_sig_n = 1'b1;
  logic       smm_ads_n = 1'b1;
  logic       bus_cyc = 1'b0;
  logic       a20m_in_n = 1'b0;
  logic       ken_in_n = 1'b0;
  logic       soft_rst_in = 1'b0;
  logic       flush_n, a20m_out_n, ken_out_n, soft_rst_out, smi_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smm_pin_ctrl i_smm_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .smm_sig_n(smm_sig_n), .smm_ads_n(smm_ads_n),
    .bus_cyc(bus_cyc), .a20m_in_n(a20m_in_n), .ken_in_n(ken_in_n),
    .soft_rst_in(soft_rst_in), .flush_n(flush_n), .a20m_out_n(a20m_out_n),
    .ken_out_n(ken_out_n), .soft_rst_out(soft_rst_out), .smi_req(smi_req)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [7:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int lows;
    // R1: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    soft_rst_in = 1'b1;
    a20m_in_n = 1'b1;
    #1;
    check("R1 rd_data", cfg_rd_data, 8'h00);
    check("R1 flush_n", {7'b0, flush_n}, 8'h01);
    check("R1 pass", {4'b0, a20m_out_n, ken_out_n, soft_rst_out, smi_req}, 8'b0000_1010);
    soft_rst_in = 1'b0;
    a20m_in_n = 1'b0;

    // R2: reserved bits read as zero
    write_mode(8'hFF);
    check("R2 ff", cfg_rd_data, 8'h1F);
    write_mode(8'hA5);
    check("R2 a5", cfg_rd_data, 8'h05);

    // Table: R3 R6 R7 R8 in the level convention
    for (int i = 0; i < NVEC; i++) begin
      write_mode({3'b000, VEC[i][13:9]});
      smm_sig_n   = VEC[i][8];
      bus_cyc     = VEC[i][7];
      a20m_in_n   = VEC[i][6];
      ken_in_n    = VEC[i][5];
      soft_rst_in = VEC[i][4];
      #1;
      check("R3/R6/R7/R8 table", {4'b0, a20m_out_n, ken_out_n, soft_rst_out, smi_req},
            {4'b0, VEC[i][3:0]});
    end
    soft_rst_in = 1'b0;
    a20m_in_n = 1'b0;
    ken_in_n = 1'b0;
    bus_cyc = 1'b0;

    // R3: level convention follows smm_sig_n in the same cycle
    write_mode(8'h04);
    smm_sig_n = 1'b1;
    #1 check("R3 out", {7'b0, a20m_out_n}, 8'h00);
    smm_sig_n = 1'b0;
    #1 check("R3 in", {7'b0, a20m_out_n}, 8'h01);

    // R5: one flush pulse per entry edge
    smm_sig_n = 1'b1;
    write_mode(8'h02);
    repeat (2) @(negedge clk);
    smm_sig_n = 1'b0;
    @(posedge clk); #1;
    check("R5 pulse low", {7'b0, flush_n}, 8'h00);
    lows = 0;
    for (int c = 0; c < 5; c++) begin
      @(posedge clk); #1;
      if (!flush_n) lows++;
    end
    check("R5 single pulse", lows[7:0], 8'h00);

    // R5: flag clear gives no pulse
    smm_sig_n = 1'b1;
    write_mode(8'h00);
    repeat (2) @(negedge clk);
    smm_sig_n = 1'b0;
    lows = 0;
    for (int c = 0; c < 4; c++) begin
      @(posedge clk); #1;
      if (!flush_n) lows++;
    end
    check("R5 disabled", lows[7:0], 8'h00);

    // R4: strobe convention with A20 override as observer
    write_mode(8'h05);
    @(negedge clk);
    smm_sig_n = 1'b1;
    smm_ads_n = 1'b0;
    @(negedge clk);
    smm_ads_n = 1'b1;
    smm_sig_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 hold out", {7'b0, a20m_out_n}, 8'h00);
    smm_ads_n = 1'b0;
    @(negedge clk);
    check("R4 strobe in", {7'b0, a20m_out_n}, 8'h01);
    smm_ads_n = 1'b1;
    smm_sig_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 hold in", {7'b0, a20m_out_n}, 8'h01);
    smm_ads_n = 1'b0;
    @(negedge clk);
    check("R4 strobe out", {7'b0, a20m_out_n}, 8'h00);
    smm_ads_n = 1'b1;

    // R1: reset clears the register again
    rst_n = 1'b0;
    #1 check("R1 reset again", cfg_rd_data, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    finish_run();
  end
endmodule